// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor core that shows the kind of each bus cycle as a 3-bit status code. It watches that code and starts a bus cycle when the code leaves the passive value. It then steps through the clock states T1, T2, T3 and T4 and produces the strobes the memory and I/O side needs. These are an address-latch pulse, a data-transceiver enable, a transfer direction, and active-low read, write and acknowledge commands. Write cycles get two write strobes. The early one opens in T2 and the normal one opens in T3.

Slow devices stretch a cycle through the `ready` input. `ready` is sampled on the clock edge that ends T3 and on the edge that ends each wait state. While it is low, wait states are inserted ahead of T4 and every active strobe holds its level. A new status code may be presented while the cycle is in T4. The next cycle then starts at once, with no idle clock between the two.

Top module: `buscmd_gen`

## Requirements
- R1: The status code selects the command. 000 gives `inta_n`. 001 gives `io_rd_n`. 010 gives `io_awr_n` and `io_wr_n`. 100 and 101 both give `mem_rd_n`. 110 gives `mem_awr_n` and `mem_wr_n`. 011 (halt) and 111 (passive) give no command.
- R2: A cycle starts only on a clock edge where the sampled status is not 111 and the status sampled on the previous edge was 111. The block must be idle or in T4 at that edge. If the status stays at a non-passive value, or moves from one active code to another without passing through 111, no further cycle starts.
- R3: `ale` is high for exactly the first clock (T1) of every cycle that starts, halt cycles included. At all other times it is low.
- R4: `den` is high from T2 through T4, wait states included, for every code except halt. It is low in T1, in idle, and for the whole of a halt cycle.
- R5: `inta_n`, `io_rd_n` and `mem_rd_n` go low from T2 through T4 in their cycles.
- R6: In write cycles the early write strobe (`io_awr_n` / `mem_awr_n`) is low from T2 through T4. The normal write strobe (`io_wr_n` / `mem_wr_n`) is low only from T3 through T4.
- R7: `ready` low at the edge ending T3 or a wait state inserts another wait state, and every strobe holds its level. `ready` high at such an edge moves the cycle to T4.
- R8: `dt_r` is low from T1 through T4 of cycles with codes 000, 001, 100 and 101. It is high at all other times.
- R9: Every command is high in idle and in T1. All commands return high on the clock after T4. At most one command family is active at any time.
- R10: Every cycle lasts at least four clocks. A cycle whose start is seen at the edge ending T4 begins its T1 on the very next clock.
- R11: While `rst_n` is low, the block is idle at once: all commands high, `ale` and `den` low, `dt_r` high. This holds even if reset arrives in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_status | input | 3 | Cycle-kind code from the processor |
| ready | input | 1 | High when the addressed device can complete the transfer |
| ale | output | 1 | Address-latch pulse during T1 |
| den | output | 1 | Data transceiver enable, active high |
| dt_r | output | 1 | Transfer direction: low = towards processor |
| inta_n | output | 1 | Interrupt acknowledge strobe |
| io_rd_n | output | 1 | I/O read command |
| io_wr_n | output | 1 | I/O write command (T3 onward) |
| io_awr_n | output | 1 | Early I/O write command (T2 onward) |
| mem_rd_n | output | 1 | Memory read command |
| mem_wr_n | output | 1 | Memory write command (T3 onward) |
| mem_awr_n | output | 1 | Early memory write command (T2 onward) |

## Verification
The assertions assume that the processor side behaves in a fixed way. Each status code is held stable across a clock edge, and the processor returns to 111 before it asks for another cycle. A passive-to-active change is never presented while a cycle is in T1, T2, T3 or a wait state, because the block would ignore it. The assertions also assume the status stays passive while reset is held. The directed stimulus changes `bus_status` and `ready` only on falling edges. It drops the status back to 111 during T1 of each cycle, and it offers a fresh code mid-cycle only in T4, which is the back-to-back case. The only exceptions are two deliberate ones: the held halt code and a direct move from one active code to another. These probe the no-retrigger rule, and neither of them crosses a running cycle.

// File: rtl/buscmd_pkg.sv
package buscmd_pkg;

   localparam int STAT_BITS = 3;

   localparam logic [STAT_BITS-1:0] CODE_ACK   = 3'b000;
   localparam logic [STAT_BITS-1:0] CODE_IORD  = 3'b001;
   localparam logic [STAT_BITS-1:0] CODE_IOWR  = 3'b010;
   localparam logic [STAT_BITS-1:0] CODE_HALT  = 3'b011;
   localparam logic [STAT_BITS-1:0] CODE_FETCH = 3'b100;
   localparam logic [STAT_BITS-1:0] CODE_MRD   = 3'b101;
   localparam logic [STAT_BITS-1:0] CODE_MWR   = 3'b110;
   localparam logic [STAT_BITS-1:0] CODE_PASV  = 3'b111;

   // command strobe indices
   localparam int NUM_CMD  = 7;
   localparam int CMD_ACK  = 0;
   localparam int CMD_IORD = 1;
   localparam int CMD_IOWR = 2;
   localparam int CMD_IOAW = 3;
   localparam int CMD_MRD  = 4;
   localparam int CMD_MWR  = 5;
   localparam int CMD_MAW  = 6;

   // strobes that open one state later (T3 instead of T2)
   localparam logic [NUM_CMD-1:0] LATE_MASK =
      (NUM_CMD'(1) << CMD_IOWR) | (NUM_CMD'(1) << CMD_MWR);

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_T1   = 3'd1,
      ST_T2   = 3'd2,
      ST_T3   = 3'd3,
      ST_TW   = 3'd4,
      ST_T4   = 3'd5
   } bus_state_e;

   typedef struct packed {
      logic [NUM_CMD-1:0] want;      // commands this cycle drives
      logic               is_input;  // data flows towards the processor
      logic               has_data;  // a transfer takes place on the data lines
   } cyc_class_t;

endpackage

// File: rtl/buscmd_status_decode.sv
module buscmd_status_decode
   import buscmd_pkg::*;
#(
   parameter int STAT_W = STAT_BITS
) (
   input  logic [STAT_W-1:0] code,
   output cyc_class_t        cls,
   output logic              passive
);

   always_comb begin
      cls      = '0;
      passive  = 1'b0;
      case (code)
         CODE_ACK: begin
            cls.want[CMD_ACK] = 1'b1;
            cls.is_input      = 1'b1;
            cls.has_data      = 1'b1;
         end
         CODE_IORD: begin
            cls.want[CMD_IORD] = 1'b1;
            cls.is_input       = 1'b1;
            cls.has_data       = 1'b1;
         end
         CODE_IOWR: begin
            cls.want[CMD_IOWR] = 1'b1;
            cls.want[CMD_IOAW] = 1'b1;
            cls.has_data       = 1'b1;
         end
         CODE_FETCH, CODE_MRD: begin
            cls.want[CMD_MRD] = 1'b1;
            cls.is_input      = 1'b1;
            cls.has_data      = 1'b1;
         end
         CODE_MWR: begin
            cls.want[CMD_MWR] = 1'b1;
            cls.want[CMD_MAW] = 1'b1;
            cls.has_data      = 1'b1;
         end
         CODE_HALT: begin
            cls = '0;
         end
         default: begin
            passive = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/buscmd_cycle_fsm.sv
module buscmd_cycle_fsm
   import buscmd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  cyc_class_t live_cls,
   input  logic       live_passive,
   input  logic       ready,
   output bus_state_e st,
   output cyc_class_t cls_q
);

   bus_state_e st_d;
   logic       prev_passive_q;
   logic       start;

   // a request is the edge from passive to any other code
   assign start = prev_passive_q & ~live_passive;

   always_comb begin
      st_d = st;
      unique case (st)
         ST_IDLE: if (start) st_d = ST_T1;
         ST_T1:   st_d = ST_T2;
         ST_T2:   st_d = ST_T3;
         ST_T3:   st_d = ready ? ST_T4 : ST_TW;
         ST_TW:   st_d = ready ? ST_T4 : ST_TW;
         ST_T4:   st_d = start ? ST_T1 : ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st             <= ST_IDLE;
         prev_passive_q <= 1'b1;
         cls_q          <= '0;
      end else begin
         st             <= st_d;
         prev_passive_q <= live_passive;
         if (st_d == ST_T1) cls_q <= live_cls;
      end
   end

endmodule

// File: rtl/buscmd_strobe_gen.sv
module buscmd_strobe_gen
   import buscmd_pkg::*;
(
   input  bus_state_e         st,
   input  cyc_class_t         cls,
   output logic               ale,
   output logic               den,
   output logic               dt_r,
   output logic [NUM_CMD-1:0] cmd_n
);

   logic early_win;
   logic late_win;

   assign early_win = (st == ST_T2) | (st == ST_T3) | (st == ST_TW) | (st == ST_T4);
   assign late_win  = (st == ST_T3) | (st == ST_TW) | (st == ST_T4);

   assign ale  = (st == ST_T1);
   assign den  = early_win & cls.has_data;
   assign dt_r = ~((st != ST_IDLE) & cls.is_input);

   for (genvar i = 0; i < NUM_CMD; i++) begin : g_cmd
      if (LATE_MASK[i]) begin : g_late
         assign cmd_n[i] = ~(cls.want[i] & late_win);
      end else begin : g_early
         assign cmd_n[i] = ~(cls.want[i] & early_win);
      end
   end

endmodule

// File: rtl/buscmd_gen.sv
module buscmd_gen
   import buscmd_pkg::*;
#(
   parameter int STAT_W = STAT_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] bus_status,
   input  logic              ready,
   output logic              ale,
   output logic              den,
   output logic              dt_r,
   output logic              inta_n,
   output logic              io_rd_n,
   output logic              io_wr_n,
   output logic              io_awr_n,
   output logic              mem_rd_n,
   output logic              mem_wr_n,
   output logic              mem_awr_n
);

   if (STAT_W != STAT_BITS) begin : g_bad_width
      $error("buscmd_gen: STAT_W must equal the status code width");
   end

   cyc_class_t         live_cls;
   cyc_class_t         cls_q;
   logic               live_passive;
   bus_state_e         st;
   logic [NUM_CMD-1:0] cmd_n;

   buscmd_status_decode #(.STAT_W(STAT_W)) u_dec (
      .code    (bus_status),
      .cls     (live_cls),
      .passive (live_passive)
   );

   buscmd_cycle_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .live_cls     (live_cls),
      .live_passive (live_passive),
      .ready        (ready),
      .st           (st),
      .cls_q        (cls_q)
   );

   buscmd_strobe_gen u_stb (
      .st    (st),
      .cls   (cls_q),
      .ale   (ale),
      .den   (den),
      .dt_r  (dt_r),
      .cmd_n (cmd_n)
   );

   assign inta_n    = cmd_n[CMD_ACK];
   assign io_rd_n   = cmd_n[CMD_IORD];
   assign io_wr_n   = cmd_n[CMD_IOWR];
   assign io_awr_n  = cmd_n[CMD_IOAW];
   assign mem_rd_n  = cmd_n[CMD_MRD];
   assign mem_wr_n  = cmd_n[CMD_MWR];
   assign mem_awr_n = cmd_n[CMD_MAW];

endmodule

// File: rtl/buscmd_gen_chk.sv
module buscmd_gen_chk
   import buscmd_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] bus_status,
   input logic       ready,
   input bus_state_e st,
   input logic       ale,
   input logic       den,
   input logic       dt_r,
   input logic       inta_n,
   input logic       io_rd_n,
   input logic       io_wr_n,
   input logic       io_awr_n,
   input logic       mem_rd_n,
   input logic       mem_wr_n,
   input logic       mem_awr_n
);

   logic [2:0] since_ale;
   logic       seen_ale;
   logic [1:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         since_ale <= '0;
         seen_ale  <= 1'b0;
         since_rst <= '0;
      end else begin
         if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
         if (ale) begin
            since_ale <= 3'd1;
            seen_ale  <= 1'b1;
         end else if (since_ale != 3'd7) begin
            since_ale <= since_ale + 3'd1;
         end
      end
   end

   // R3
   ale_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ale |=> !ale);

   // R2
   start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ale && since_rst >= 2'd2) |-> ($past(bus_status, 2) == CODE_PASV && $past(bus_status) != CODE_PASV));

   // R9
   one_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({~inta_n, ~io_rd_n, ~(io_wr_n & io_awr_n), ~mem_rd_n, ~(mem_wr_n & mem_awr_n)}) <= 1);

   // R6
   io_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_wr_n |-> !io_awr_n);

   // R6
   mem_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_wr_n) |-> (!mem_awr_n && $past(!mem_awr_n)));

   // R10
   min_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ale && seen_ale) |-> since_ale >= 3'd4);

   // R7
   wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_T3 || st == ST_TW) && !ready) |=> (st == ST_TW && $stable({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, inta_n})));

   // R7
   wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_T3 || st == ST_TW) && ready) |=> st == ST_T4);

   // R8
   dir_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && st != ST_T1) |-> $stable(dt_r));

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE || st == ST_T1) |-> (&{inta_n, io_rd_n, io_wr_n, io_awr_n, mem_rd_n, mem_wr_n, mem_awr_n} && !den));

endmodule

bind buscmd_gen buscmd_gen_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_status (bus_status),
   .ready      (ready),
   .st         (st),
   .ale        (ale),
   .den        (den),
   .dt_r       (dt_r),
   .inta_n     (inta_n),
   .io_rd_n    (io_rd_n),
   .io_wr_n    (io_wr_n),
   .io_awr_n   (io_awr_n),
   .mem_rd_n   (mem_rd_n),
   .mem_wr_n   (mem_wr_n),
   .mem_awr_n  (mem_awr_n)
);

// File: tb/buscmd_gen_bench.sv
`timescale 1ns/1ps
module buscmd_gen_bench;

   localparam logic [2:0] PASV = 3'b111;
   // bench phase numbering: 0 idle, 1 T1, 2 T2, 3 T3, 4 wait, 5 T4
   localparam int P_IDLE = 0, P_T1 = 1, P_T2 = 2, P_T3 = 3, P_TW = 4, P_T4 = 5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] bus_status = PASV;
   logic       ready = 1'b1;
   logic       ale, den, dt_r;
   logic       inta_n, io_rd_n, io_wr_n, io_awr_n, mem_rd_n, mem_wr_n, mem_awr_n;

   int vectors = 0;
   int fails   = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   buscmd_gen u_buscmd_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_status (bus_status),
      .ready      (ready),
      .ale        (ale),
      .den        (den),
      .dt_r       (dt_r),
      .inta_n     (inta_n),
      .io_rd_n    (io_rd_n),
      .io_wr_n    (io_wr_n),
      .io_awr_n   (io_awr_n),
      .mem_rd_n   (mem_rd_n),
      .mem_wr_n   (mem_wr_n),
      .mem_awr_n  (mem_awr_n)
   );

   // order: ale den dt_r inta io_rd io_wr io_awr mem_rd mem_wr mem_awr
   function automatic logic [9:0] expect_vec(input int ph, input logic [2:0] code);
      logic early, late, is_in, has_d;
      early = (ph >= P_T2);
      late  = (ph >= P_T3);
      is_in = (code == 3'b000) || (code == 3'b001) || (code == 3'b100) || (code == 3'b101);
      has_d = (code != 3'b011) && (code != PASV);
      return { ph == P_T1,
               early & has_d,
               ~((ph != P_IDLE) & is_in),
               ~((code == 3'b000) & early),
               ~((code == 3'b001) & early),
               ~((code == 3'b010) & late),
               ~((code == 3'b010) & early),
               ~(((code == 3'b100) || (code == 3'b101)) & early),
               ~((code == 3'b110) & late),
               ~((code == 3'b110) & early) };
   endfunction

   task automatic check(input int ph, input logic [2:0] code, input string tag);
      logic [9:0] got, exp;
      got = {ale, den, dt_r, inta_n, io_rd_n, io_wr_n, io_awr_n, mem_rd_n, mem_wr_n, mem_awr_n};
      exp = expect_vec(ph, code);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s phase=%0d code=%b actual=%b expected=%b", tag, ph, code, got, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
      #1;
   endtask

   // runs T1..T4 of a cycle whose start code is already on the bus
   task automatic phases(input logic [2:0] code, input int waits, input logic [2:0] hand_off,
                         input bit hold, input string tag);
      tick; check(P_T1, code, tag);
      if (!hold) bus_status = PASV;
      tick; check(P_T2, code, tag);
      if (waits > 0) ready = 1'b0;
      tick; check(P_T3, code, tag);
      for (int w = 1; w <= waits; w++) begin
         tick; check(P_TW, code, tag);
         if (w == waits) ready = 1'b1;
      end
      tick; check(P_T4, code, tag);
      if (hand_off != PASV) bus_status = hand_off;
   endtask

   task automatic run_cycle(input logic [2:0] code, input int waits, input string tag);
      @(negedge clk); bus_status = code; ready = 1'b1;
      phases(code, waits, PASV, 1'b0, tag);
      tick; check(P_IDLE, PASV, tag);
   endtask

   task automatic test_reset;
      // R11
      check(P_IDLE, PASV, "R11 reset idle");
      @(negedge clk); rst_n = 1'b1;
      tick; check(P_IDLE, PASV, "R11 after release");
   endtask

   task automatic test_each_code;
      // R1 R3 R4 R5 R6 R8 R9: every code, no waits
      run_cycle(3'b000, 0, "R1 R5 ack");
      run_cycle(3'b001, 0, "R1 R5 io read");
      run_cycle(3'b010, 0, "R1 R6 io write");
      run_cycle(3'b100, 0, "R1 R8 fetch");
      run_cycle(3'b101, 0, "R1 R5 mem read");
      run_cycle(3'b110, 0, "R1 R6 mem write");
      run_cycle(3'b011, 0, "R4 halt cycle");
   endtask

   task automatic test_waits;
      // R7
      run_cycle(3'b110, 2, "R7 mem write waits");
      run_cycle(3'b001, 3, "R7 io read waits");
      run_cycle(3'b000, 1, "R7 ack wait");
   endtask

   task automatic test_no_retrigger;
      // R2: held halt starts exactly one cycle
      @(negedge clk); bus_status = 3'b011; ready = 1'b1;
      phases(3'b011, 0, PASV, 1'b1, "R2 halt held");
      for (int i = 0; i < 5; i++) begin
         tick; check(P_IDLE, PASV, "R2 halt no retrigger");
      end
      // R2: active to active with no passive step starts nothing
      bus_status = 3'b101;
      for (int i = 0; i < 4; i++) begin
         tick; check(P_IDLE, PASV, "R2 code swap ignored");
      end
      bus_status = PASV;
      tick; check(P_IDLE, PASV, "R2 back to passive");
   endtask

   task automatic test_back_to_back;
      // R10: next start seen at T4 begins T1 straight away
      @(negedge clk); bus_status = 3'b101; ready = 1'b1;
      phases(3'b101, 0, 3'b010, 1'b0, "R10 first");
      phases(3'b010, 1, PASV, 1'b0, "R10 chained");
      tick; check(P_IDLE, PASV, "R10 idle after chain");
   endtask

   task automatic test_mid_reset;
      // R11: reset inside a cycle
      @(negedge clk); bus_status = 3'b110; ready = 1'b1;
      tick; check(P_T1, 3'b110, "R11 pre reset T1");
      bus_status = PASV;
      tick; check(P_T2, 3'b110, "R11 pre reset T2");
      rst_n = 1'b0;
      #1; check(P_IDLE, PASV, "R11 async reset");
      @(negedge clk); rst_n = 1'b1;
      tick; check(P_IDLE, PASV, "R11 idle after reset");
      run_cycle(3'b001, 0, "R11 cycle after reset");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      test_reset;
      test_each_code;
      test_waits;
      test_no_retrigger;
      test_back_to_back;
      test_mid_reset;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule